// File: doc/BRIEF.md
# Power-On Register Initialization Sequencer

This block brings a bank of live configuration registers up from their persistent copies after reset. When reset deasserts it walks through the persistent array one register at a time. For each register it presents the address, takes the returned word and pulses the write enable of the matching live register. The channel data registers (indices 0 to NUM_CH-1) are copied first and the combined mute/shutdown register (index NUM_CH) is copied last.

Until that final copy has landed, the block keeps every channel output forced to mute and holds the serial interface locked. One cycle after the last write it releases both. It also pulses a one-cycle done strobe as the interface opens, and it stays released until the next reset. The whole walk takes INIT_CYCLES clock cycles. That time is split evenly into NUM_CH+1 steps of STEP = INIT_CYCLES/(NUM_CH+1) cycles, so the copy runs at the pace of a slow local timebase. Reset also clears the live registers through a dedicated clear output.

The state machine has four states. ST_CLEAR is entered by reset and drives the clear and mute outputs. ST_LOAD counts through the steps and writes one register at the end of each. ST_RELEASE lasts one cycle, opens the interface and raises done. ST_HOLD is the permanent released state. The transitions are: reset to ST_CLEAR; ST_CLEAR to ST_LOAD on the first edge after reset; ST_LOAD to ST_RELEASE when the last step of the mute/shutdown register ends; ST_RELEASE to ST_HOLD unconditionally; ST_HOLD to itself.

Top module: `pwr_init_seq`

## Requirements
- R1: While rst_n is low, and until the first clock edge after it rises, clr_live and force_mute are 1, while if_enable, init_done and every wr_en bit are 0.
- R2: Exactly NUM_CH+1 writes occur, one per cycle at most, in index order 0,1,...,NUM_CH. wr_en bit k selects live register k, and bit NUM_CH (the mute/shutdown register) is written last.
- R3: Count the edges after reset release from n=0. The write of index k is visible in the cycle after edge n = k*STEP + STEP-1, where STEP = INIT_CYCLES/(NUM_CH+1). No write occurs in any other cycle.
- R4: During a write, rd_addr equals the index being written and wr_data equals rd_data from the persistent array.
- R5: force_mute stays 1 and if_enable stays 0 up to and including the cycle of the mute/shutdown write. Both change in the cycle after it, at n = (NUM_CH+1)*STEP.
- R6: init_done is high for exactly one cycle, the cycle in which if_enable first rises.
- R7: After release, if_enable stays 1, force_mute stays 0 and no write occurs until the next reset, whatever the persistent array returns.
- R8: A reset asserted partway through the copy returns the block to the R1 state. The next run starts again from index 0 with the full R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the local timebase |
| rst_n | input | 1 | Active-low asynchronous reset (power-on) |
| rd_addr | output | $clog2(NUM_CH+1) | Read address into the persistent array |
| rd_data | input | DATA_W | Word returned by the persistent array for rd_addr, same cycle |
| wr_en | output | NUM_CH+1 | One-hot write enables for the live registers |
| wr_data | output | DATA_W | Word written into the enabled live register |
| clr_live | output | 1 | Clears all live registers while high |
| force_mute | output | 1 | Forces every channel output into mute |
| if_enable | output | 1 | Enables the serial interface |
| init_done | output | 1 | One-cycle strobe when the interface is enabled |

## Verification
The assertions assume that the persistent array answers combinationally: rd_data must be valid in the same cycle as rd_addr, or the write-data relation would not hold. They also assume that rst_n changes away from the active clock edge, so the first post-reset cycle is well defined. The bench models the persistent array as a lookup on rd_addr and drives rst_n only on falling clock edges. It changes the array contents only between runs, or after release when the block must ignore them.

// File: rtl/pwr_init_pkg.sv
package pwr_init_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR   = 2'd0,
        ST_LOAD    = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HOLD    = 2'd3
    } init_state_e;

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
    parameter int STEP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_end
);
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign step_end = run && (cnt == LAST);

    // R3: dwell counter never passes the step length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3: a finished step restarts the dwell from zero
    p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_end |=> (cnt == '0));

endmodule

// File: rtl/init_reg_index.sv
module init_reg_index #(
    parameter int NUM_REGS = 5,
    parameter int AW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          advance,
    output logic [AW-1:0] idx,
    output logic          idx_last
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NUM_REGS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (!run) begin
            idx <= '0;
        end else if (advance && (idx != LAST_IDX)) begin
            idx <= idx + AW'(1);
        end
    end

    assign idx_last = (idx == LAST_IDX);

    // R2: index stays inside the register set
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // R2: indices are visited in ascending order, one per step
    p_idx_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && advance && !idx_last) |=> (idx == $past(idx) + AW'(1)));

endmodule

// File: rtl/init_we_decode.sv
module init_we_decode #(
    parameter int NUM_REGS = 5,
    parameter int AW       = 3
) (
    input  logic                fire,
    input  logic [AW-1:0]       idx,
    output logic [NUM_REGS-1:0] we
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign we[g] = fire && (idx == AW'(g));
    end

endmodule

// File: rtl/pwr_init_seq.sv
module pwr_init_seq
    import pwr_init_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = 8,
    parameter int INIT_CYCLES = 40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    output logic [$clog2(NUM_CH+1)-1:0]     rd_addr,
    input  logic [DATA_W-1:0]               rd_data,
    output logic [NUM_CH:0]                 wr_en,
    output logic [DATA_W-1:0]               wr_data,
    output logic                            clr_live,
    output logic                            force_mute,
    output logic                            if_enable,
    output logic                            init_done
);
    localparam int NUM_REGS    = NUM_CH + 1;
    localparam int AW          = $clog2(NUM_REGS);
    localparam int STEP_CYCLES = INIT_CYCLES / NUM_REGS;

    init_state_e state, state_nx;

    logic          run;
    logic          step_end;
    logic          fire;
    logic [AW-1:0] idx;
    logic          idx_last;

    assign run  = (state == ST_LOAD);
    assign fire = run && step_end;

    init_step_timer #(
        .STEP_CYCLES (STEP_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .step_end (step_end)
    );

    init_reg_index #(
        .NUM_REGS (NUM_REGS),
        .AW       (AW)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .advance  (step_end),
        .idx      (idx),
        .idx_last (idx_last)
    );

    init_we_decode #(
        .NUM_REGS (NUM_REGS),
        .AW       (AW)
    ) u_decode (
        .fire (fire),
        .idx  (idx),
        .we   (wr_en)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR:   state_nx = ST_LOAD;
            ST_LOAD:    if (step_end && idx_last) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_HOLD;
            ST_HOLD:    state_nx = ST_HOLD;
            default:    state_nx = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clr_live   = 1'b0;
        force_mute = 1'b1;
        if_enable  = 1'b0;
        init_done  = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                clr_live = 1'b1;
            end
            ST_LOAD: begin
                force_mute = 1'b1;
            end
            ST_RELEASE: begin
                force_mute = 1'b0;
                if_enable  = 1'b1;
                init_done  = 1'b1;
            end
            ST_HOLD: begin
                force_mute = 1'b0;
                if_enable  = 1'b1;
            end
            default: begin
                clr_live = 1'b1;
            end
        endcase
    end

    assign rd_addr = idx;
    assign wr_data = rd_data;

    // R1: clear phase never writes and keeps outputs muted and interface shut
    p_clear_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_live |-> ((wr_en == '0) && force_mute && !if_enable));

    // R2: at most one live register written per cycle
    p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R2: mute/shutdown write is the final one, release follows at once
    p_ms_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[NUM_CH] |=> (if_enable && init_done));

    // R4: write enable matches the address being read
    p_addr_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> (wr_en == (NUM_REGS'(1) << rd_addr)));

    // R5: interface opens only right after the mute/shutdown write
    p_release_after_ms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_enable) |-> $past(wr_en[NUM_CH]));

    // R5: outputs stay muted while the interface is locked
    p_mute_while_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !if_enable |-> force_mute);

    // R6: done is a single-cycle strobe aligned with the enable rise
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);

    p_done_with_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> $rose(if_enable));

    // R7: release is permanent and write-free until reset
    p_enable_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        if_enable |=> (if_enable && !force_mute));

    p_no_write_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        if_enable |-> (wr_en == '0));

endmodule

// File: tb/pwr_init_seq_test.sv
module pwr_init_seq_test;

    localparam int NUM_CH   = 4;
    localparam int DATA_W   = 8;
    localparam int INIT     = 40;
    localparam int NREG     = NUM_CH + 1;
    localparam int AW       = $clog2(NREG);
    localparam int STEP     = INIT / NREG;
    localparam int LOAD_END = NREG * STEP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_CH:0]   wr_en;
    logic [DATA_W-1:0] wr_data;
    logic              clr_live;
    logic              force_mute;
    logic              if_enable;
    logic              init_done;

    logic [DATA_W-1:0] mem [NREG];

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    assign rd_data = (int'(rd_addr) < NREG) ? mem[rd_addr] : '0;

    pwr_init_seq #(
        .NUM_CH      (NUM_CH),
        .DATA_W      (DATA_W),
        .INIT_CYCLES (INIT)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .clr_live   (clr_live),
        .force_mute (force_mute),
        .if_enable  (if_enable),
        .init_done  (init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic fill_mem(input logic [7:0] seed);
        for (int k = 0; k < NREG; k++) mem[k] = seed ^ 8'(k * 37);
    endtask

    // R1: reset state, including the first cycle after release
    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(clr_live == 1'b1,   "R1", "clr_live in reset",   int'(clr_live), 1);
        chk(force_mute == 1'b1, "R1", "force_mute in reset", int'(force_mute), 1);
        chk(if_enable == 1'b0,  "R1", "if_enable in reset",  int'(if_enable), 0);
        chk(init_done == 1'b0,  "R1", "init_done in reset",  int'(init_done), 0);
        chk(wr_en == '0,        "R1", "wr_en in reset",      int'(wr_en), 0);
        rst_n = 1'b1;
        #1;
        chk(clr_live == 1'b1,   "R1", "clr_live before first edge", int'(clr_live), 1);
        chk(wr_en == '0,        "R1", "wr_en before first edge",    int'(wr_en), 0);
    endtask

    // R2 R3 R4 R5 R6: cycle-by-cycle walk through the copy
    task automatic t_sequence(input int last_n);
        for (int n = 0; n <= last_n; n++) begin
            int  k;
            bit  wr;
            int  exp_we;
            @(posedge clk);
            @(negedge clk);
            k      = n / STEP;
            wr     = (n < LOAD_END) && ((n % STEP) == STEP - 1);
            exp_we = wr ? (1 << k) : 0;
            chk(int'(wr_en) == exp_we, "R3", "wr_en timing/order (R2)", int'(wr_en), exp_we);
            if (wr) begin
                chk(int'(rd_addr) == k, "R4", "rd_addr at write", int'(rd_addr), k);
                chk(wr_data == mem[k],  "R4", "wr_data at write", int'(wr_data), int'(mem[k]));
            end
            chk(force_mute == (n < LOAD_END), "R5", "force_mute", int'(force_mute), int'(n < LOAD_END));
            chk(if_enable == (n >= LOAD_END), "R5", "if_enable",  int'(if_enable),  int'(n >= LOAD_END));
            chk(init_done == (n == LOAD_END), "R6", "init_done",  int'(init_done),  int'(n == LOAD_END));
            chk(clr_live == 1'b0, "R1", "clr_live after first edge", int'(clr_live), 0);
        end
    endtask

    task automatic t_full_run(input logic [7:0] seed);
        fill_mem(seed);
        t_reset_state();
        t_sequence(LOAD_END + 3);
    endtask

    // R7: released state ignores the persistent array
    task automatic t_hold_ignore();
        fill_mem(8'hC3);
        for (int n = 0; n < 20; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 7) fill_mem(8'h3C);
            chk(wr_en == '0,        "R7", "wr_en after release",      int'(wr_en), 0);
            chk(if_enable == 1'b1,  "R7", "if_enable after release",  int'(if_enable), 1);
            chk(force_mute == 1'b0, "R7", "force_mute after release", int'(force_mute), 0);
            chk(init_done == 1'b0,  "R7", "init_done after release",  int'(init_done), 0);
        end
    endtask

    // R8: reset in the middle of the copy restarts from index 0
    task automatic t_mid_reset();
        fill_mem(8'h81);
        t_reset_state();
        t_sequence(2 * STEP + 2);
        fill_mem(8'h17);
        t_reset_state();
        chk(clr_live == 1'b1, "R8", "clr_live after mid reset", int'(clr_live), 1);
        t_sequence(LOAD_END + 2);
    endtask

    initial begin
        fill_mem(8'h00);
        t_full_run(8'h5A);
        t_hold_ignore();
        t_full_run(8'hFF);
        t_mid_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule